// File: doc/BRIEF.md
# Edge Timestamp Capture with Glitch Filter

This block records when an external signal changes level. It watches an asynchronous capture pin and, on the chosen edge direction, stores the value of a free-running counter (supplied from outside) in a capture register. A sticky flag marks each new timestamp, and the block raises an interrupt request when the flag is set and the interrupt is enabled. Software acknowledges the event by writing a clear pulse.

The pin is first brought into the clock domain by a flop chain. An optional filter can then sit in front of the edge detector. With the filter on, a new level is accepted only after the same level has been seen on four successive clock cycles. This rejects short glitches, and every capture arrives four cycles later. When the surrounding timer uses the capture register as its period limit, the pin is shut out and software may load the register directly.

Top module: `capture_stamp`

## Requirements
- R1: While `rst_n` is low and after its release, `cap_value` is 0 and `cap_flag` and `cap_irq` are 0 until a capture happens.
- R2: With `filt_en`=0 and `edge_rise`=1, a 0-to-1 change of `pin_raw` before rising clock edge E0 loads `count_val` as sampled at edge E2 into `cap_value` and sets `cap_flag` at E2. Before E2 the flag is still 0.
- R3: With `edge_rise`=0, a 1-to-0 change of `pin_raw` causes the capture with the timing of R2. A 0-to-1 change with `edge_rise`=0 causes no capture.
- R4: With `filt_en`=1, a level change held steady is captured at edge E6, four cycles later than in R2. `cap_value` takes the `count_val` seen at E6.
- R5: With `filt_en`=1, a pulse lasting three clock cycles causes no capture. A pulse lasting four cycles is captured.
- R6: `cap_irq` is 1 exactly when `cap_flag` is 1 and `irq_en` is 1.
- R7: `cap_flag` stays 1 until a cycle with `flag_clr`=1 and no capture. If a capture and `flag_clr` fall on the same edge, the flag stays 1.
- R8: While `top_sel`=1, edges on `pin_raw` cause no capture. `cap_flag` and `cap_value` do not change from pin activity.
- R9: A cycle with `reg_wr`=1 and `top_sel`=1 loads `reg_wdata` into `cap_value` at that edge. With `top_sel`=0 the write has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_raw | input | 1 | Asynchronous capture pin |
| count_val | input | CW | Current value of the free-running counter |
| filt_en | input | 1 | 1 enables the four-sample glitch filter |
| edge_rise | input | 1 | 1 captures on rising edges, 0 on falling edges |
| irq_en | input | 1 | Capture interrupt enable |
| top_sel | input | 1 | 1 when the capture register serves as counter period limit |
| flag_clr | input | 1 | One-cycle pulse that clears the capture flag |
| reg_wr | input | 1 | Software write strobe for the capture register |
| reg_wdata | input | CW | Software write data |
| cap_value | output | CW | Capture register |
| cap_flag | output | 1 | Sticky capture flag |
| cap_irq | output | 1 | Interrupt request |

## Verification
Counted from the rising clock edge E0 that first samples a pin change, an unfiltered capture is due at E2: two synchronizer flops, then the detector and the register. A filtered capture is due at E6. Each scenario task notes the bench counter value at the falling edge where it changes the pin. It checks that the flag is still clear at the falling edge just before the due edge, then checks the flag and the expected counter value (noted value plus 2, or plus 6) at the falling edge just after it. Flag clears, interrupt enables and register writes act at the next rising edge, so they are checked one half-cycle later.

// File: rtl/cs_pkg.sv
// Shared types for the capture-stamp block.
// Assumes: nothing beyond IEEE 1800-2017.
package cs_pkg;
    typedef enum logic {
        POL_FALL = 1'b0,
        POL_RISE = 1'b1
    } cs_pol_e;
endpackage

// File: rtl/cs_sync.sv
// Multi-flop synchronizer bringing the asynchronous pin into the clock domain.
// Assumes: STAGES >= 2; resets the chain to 0.
module cs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    // Shift the pin through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_async};
    end

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/cs_filter.sv
// Glitch filter: the output takes a new level only once SAMPLES successive
// samples (the current input plus SAMPLES-1 stored ones) all agree.
// When disabled, the synchronized input passes straight through.
// Assumes: SAMPLES >= 2; input already synchronized.
module cs_filter #(
    parameter int SAMPLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic din,
    output logic dout
);
    localparam int HIST_W = SAMPLES - 1;

    logic [HIST_W-1:0] hist_q;
    logic              level_q;
    logic [SAMPLES-1:0] window;
    logic               all_hi;
    logic               all_lo;

    assign window = {hist_q, din};
    assign all_hi = &window;
    assign all_lo = ~|window;

    // Keep the recent sample history.
    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= window[HIST_W-1:0];
    end

    // Move the filtered level only on a unanimous window.
    always_ff @(posedge clk) begin
        if (!rst_n)      level_q <= 1'b0;
        else if (all_hi) level_q <= 1'b1;
        else if (all_lo) level_q <= 1'b0;
    end

    assign dout = enable ? level_q : din;
endmodule

// File: rtl/cs_edge.sv
// Edge detector with selectable polarity; flags one cycle per qualifying edge.
// Assumes: input is synchronous to clk.
module cs_edge
    import cs_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  cs_pol_e pol,
    input  logic    lvl,
    output logic    hit
);
    logic prev_q;

    // Remember the previous level for comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    assign hit = (pol == POL_RISE) ? (lvl & ~prev_q) : (~lvl & prev_q);
endmodule

// File: rtl/capture_stamp.sv
// Capture-stamp top: synchronizer -> optional glitch filter -> edge detector,
// then the capture register, sticky flag and interrupt request.
// Assumes: count_val is synchronous to clk; flag_clr is a single-cycle pulse.
module capture_stamp
    import cs_pkg::*;
#(
    parameter int CW          = 16,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pin_raw,
    input  logic [CW-1:0] count_val,
    input  logic          filt_en,
    input  logic          edge_rise,
    input  logic          irq_en,
    input  logic          top_sel,
    input  logic          flag_clr,
    input  logic          reg_wr,
    input  logic [CW-1:0] reg_wdata,
    output logic [CW-1:0] cap_value,
    output logic          cap_flag,
    output logic          cap_irq
);
    logic pin_sync;
    logic pin_lvl;
    logic edge_hit;
    logic cap_evt;

    cs_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_raw),
        .q_sync  (pin_sync)
    );

    cs_filter #(.SAMPLES(FILT_LEN)) filt_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (filt_en),
        .din    (pin_sync),
        .dout   (pin_lvl)
    );

    cs_edge edge_i (
        .clk   (clk),
        .rst_n (rst_n),
        .pol   (cs_pol_e'(edge_rise)),
        .lvl   (pin_lvl),
        .hit   (edge_hit)
    );

    assign cap_evt = edge_hit & ~top_sel;

    // Load the timestamp on capture, or software data while acting as TOP.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cap_value <= '0;
        else if (cap_evt)           cap_value <= count_val;
        else if (reg_wr && top_sel) cap_value <= reg_wdata;
    end

    // Sticky flag: a capture wins over a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        cap_flag <= 1'b0;
        else if (cap_evt)  cap_flag <= 1'b1;
        else if (flag_clr) cap_flag <= 1'b0;
    end

    assign cap_irq = cap_flag & irq_en;
endmodule

// File: rtl/cs_checker.sv
// Property checker for capture_stamp, attached by bind below.
// Assumes: observes top-level ports only.
module cs_checker #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          irq_en,
    input logic          top_sel,
    input logic          flag_clr,
    input logic          reg_wr,
    input logic [CW-1:0] reg_wdata,
    input logic [CW-1:0] cap_value,
    input logic          cap_flag,
    input logic          cap_irq
);
    assert_reset_flag_R1: assert property (@(posedge clk)
        !rst_n |=> !cap_flag);

    assert_irq_needs_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cap_irq |-> (cap_flag && irq_en));

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_flag && !flag_clr) |=> cap_flag);

    assert_top_no_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (top_sel && !cap_flag) |=> !cap_flag);

    assert_top_value_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (top_sel && !reg_wr) |=> $stable(cap_value));

    assert_top_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (top_sel && reg_wr) |=> (cap_value == $past(reg_wdata)));

    assert_change_sets_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(cap_value) && !$past(top_sel && reg_wr) && $past(rst_n)) |-> cap_flag);
endmodule

bind capture_stamp cs_checker #(.CW(CW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_en    (irq_en),
    .top_sel   (top_sel),
    .flag_clr  (flag_clr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .cap_value (cap_value),
    .cap_flag  (cap_flag),
    .cap_irq   (cap_irq)
);

// File: tb/capture_stamp_tb_top.sv
`timescale 1ns/1ps
// Directed bench for capture_stamp: one task per scenario.
module capture_stamp_tb_top;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pin_raw = 1'b0;
    logic [CW-1:0] cnt = '0;
    logic          filt_en = 1'b0;
    logic          edge_rise = 1'b1;
    logic          irq_en = 1'b0;
    logic          top_sel = 1'b0;
    logic          flag_clr = 1'b0;
    logic          reg_wr = 1'b0;
    logic [CW-1:0] reg_wdata = '0;
    logic [CW-1:0] cap_value;
    logic          cap_flag;
    logic          cap_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    // Free-running counter feeding the block.
    always @(posedge clk) cnt <= cnt + 1'b1;

    capture_stamp #(.CW(CW)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_raw   (pin_raw),
        .count_val (cnt),
        .filt_en   (filt_en),
        .edge_rise (edge_rise),
        .irq_en    (irq_en),
        .top_sel   (top_sel),
        .flag_clr  (flag_clr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .cap_value (cap_value),
        .cap_flag  (cap_flag),
        .cap_irq   (cap_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_flag();
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
        check("R7 clear", cap_flag, 0);
    endtask

    // Change the pin; return the counter value seen at that falling edge.
    task automatic set_pin(input logic lvl, output logic [CW-1:0] c);
        @(negedge clk);
        pin_raw = lvl;
        c = cnt;
    endtask

    task automatic t_reset();
        cycles(4);
        check("R1 value in reset", cap_value, 0);
        check("R1 flag in reset", cap_flag, 0);
        rst_n = 1'b1;
        cycles(3);
        check("R1 value after reset", cap_value, 0);
        check("R1 irq after reset", cap_irq, 0);
    endtask

    task automatic t_rise();
        logic [CW-1:0] c;
        filt_en = 0; edge_rise = 1; irq_en = 0;
        set_pin(1'b1, c);
        cycles(2);
        check("R2 flag not before E2", cap_flag, 0);
        cycles(1);
        check("R2 flag at E2", cap_flag, 1);
        check("R2 value", cap_value, 32'(CW'(c + 2)));
        check("R6 irq masked", cap_irq, 0);
        @(negedge clk); irq_en = 1'b1;
        @(negedge clk);
        check("R6 irq raised", cap_irq, 1);
        cycles(10);
        check("R7 flag held", cap_flag, 1);
        clear_flag();
        check("R6 irq dropped", cap_irq, 0);
    endtask

    task automatic t_fall();
        logic [CW-1:0] c;
        edge_rise = 0;
        cycles(2);
        set_pin(1'b0, c);
        cycles(2);
        check("R3 flag not before E2", cap_flag, 0);
        cycles(1);
        check("R3 flag on falling", cap_flag, 1);
        check("R3 value", cap_value, 32'(CW'(c + 2)));
        clear_flag();
        set_pin(1'b1, c);
        cycles(8);
        check("R3 rising ignored", cap_flag, 0);
    endtask

    task automatic t_filter();
        logic [CW-1:0] c;
        // pin is 1 and steady; filter output already follows it
        edge_rise = 1; filt_en = 1;
        cycles(2);
        set_pin(1'b0, c);
        cycles(10);
        check("R4 no capture on falling", cap_flag, 0);
        set_pin(1'b1, c);
        cycles(6);
        check("R4 flag not before E6", cap_flag, 0);
        cycles(1);
        check("R4 flag at E6", cap_flag, 1);
        check("R4 value", cap_value, 32'(CW'(c + 6)));
        clear_flag();
    endtask

    task automatic t_glitch();
        logic [CW-1:0] c;
        edge_rise = 0; filt_en = 1;
        set_pin(1'b0, c);
        cycles(2);
        @(negedge clk); pin_raw = 1'b1;
        cycles(12);
        check("R5 3-cycle pulse rejected", cap_flag, 0);
        set_pin(1'b0, c);
        cycles(3);
        @(negedge clk); pin_raw = 1'b1;
        cycles(12);
        check("R5 4-cycle pulse accepted", cap_flag, 1);
        clear_flag();
    endtask

    task automatic t_clr_priority();
        logic [CW-1:0] c;
        filt_en = 0; edge_rise = 1;
        set_pin(1'b0, c);
        cycles(6);
        set_pin(1'b1, c);
        cycles(8);
        check("R7 setup capture", cap_flag, 1);
        set_pin(1'b0, c);
        cycles(6);
        set_pin(1'b1, c);
        cycles(2);
        flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
        check("R7 capture beats clear", cap_flag, 1);
        check("R7 value on collision", cap_value, 32'(CW'(c + 2)));
        clear_flag();
    endtask

    task automatic t_top();
        logic [CW-1:0] c;
        logic [CW-1:0] held;
        held = cap_value;
        @(negedge clk); top_sel = 1'b1;
        set_pin(1'b0, c);
        cycles(6);
        set_pin(1'b1, c);
        cycles(8);
        check("R8 no flag while top", cap_flag, 0);
        check("R8 value held while top", cap_value, 32'(held));
        @(negedge clk); reg_wr = 1'b1; reg_wdata = 16'hBEEF;
        @(negedge clk); reg_wr = 1'b0;
        check("R9 write while top", cap_value, 32'h0000BEEF);
        top_sel = 1'b0;
        cycles(4);
        check("R8 no late capture", cap_flag, 0);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = 16'h1234;
        @(negedge clk); reg_wr = 1'b0;
        check("R9 write ignored when not top", cap_value, 32'h0000BEEF);
    endtask

    initial begin
        t_reset();
        t_rise();
        t_fall();
        t_filter();
        t_glitch();
        t_clr_priority();
        t_top();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule